// File: doc/BRIEF.md
# Codec Serial Control Register

This block holds the eight-bit control word of a voice codec. A host writes the word over a three-wire serial link made of an enable line, a data clock and a data line. While the enable line is low, each rising data clock edge shifts one bit in, most significant bit first. A rising edge on the enable line copies the shift register into the active control word.

The active word is decoded into three groups of select signals for the analog section. The first is a one-hot transmit input select: mute, first microphone input, second input, or the sum of both. The second is a one-hot receive output select, together with enable lines for the differential driver and the auxiliary output. The third is a three-bit attenuation index plus the same step expressed in dB. A one-cycle update pulse marks each commit.

The active-low power-down input forces the defined initial word. That word selects the first microphone input, turns the differential driver on, leaves the auxiliary output at ground and sets 0 dB. The initial word stays in force after release until a new word is committed. All three serial pins are synchronised into the system clock domain, and their edges are detected there.

Top module: `codec_ctl_reg`

## Requirements
- R1: While `ctl_en` is low, each rising edge of `ctl_clk` shifts `ctl_dat` into the shift register, most significant bit first. After eight shifts, the first bit sent sits in bit 7.
- R2: A rising edge of `ctl_en` commits the current shift register contents to the active word. After fewer than eight shifts, the committed word is the older contents moved up by the number of new bits, with the new bits below them.
- R3: Transmit select: the index is {bit 6, bit 7} of the active word, and `tx_sel` is one-hot at that index. Bit 0 is mute, bit 1 the first microphone input, bit 2 the second input and bit 3 the sum of both.
- R4: Receive select: the index is {bit 4, bit 5}, and `rx_sel` is one-hot at that index. Bit 0 puts both outputs at ground, bit 1 enables the driver only, bit 2 the auxiliary only and bit 3 both. `rx_drv_en` equals bit 5 and `rx_aux_en` equals bit 4.
- R5: `vol_idx` equals bits 2..0, and `atten_db` equals 4 times `vol_idx` (0 to 28 dB of attenuation). Bit 3 has no effect on any output.
- R6: While `pdn_n` is low, the active word is 8'hA0: `tx_sel`=4'b0010, `rx_sel`=4'b0010, `rx_drv_en`=1, `rx_aux_en`=0, `vol_idx`=0, `atten_db`=0 and `upd`=0. The shift register is cleared to zero.
- R7: After `pdn_n` rises, the outputs keep their initial values until a commit. Data clock activity without a rising enable edge leaves every output unchanged.
- R8: Each commit produces exactly one `upd` pulse lasting one cycle. The decoded outputs change only in the cycle in which `upd` is high.
- R9: Rising data clock edges while `ctl_en` is high are ignored, and the shift register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down; restores the initial word |
| ctl_en | input | 1 | Serial enable; low while shifting, rising edge commits |
| ctl_clk | input | 1 | Serial data clock |
| ctl_dat | input | 1 | Serial data, most significant bit first |
| tx_sel | output | 4 | One-hot transmit input select |
| rx_sel | output | 4 | One-hot receive output select |
| rx_drv_en | output | 1 | Differential receive driver active |
| rx_aux_en | output | 1 | Auxiliary output fed from the converter |
| vol_idx | output | 3 | Attenuation step index |
| atten_db | output | 5 | Attenuation in dB (4 dB per step) |
| upd | output | 1 | One-cycle pulse per commit |

## Verification
A wrong shift register state does not appear on the outputs at once. It shows up only at the next commit, about four system clocks after the enable edge, as a wrong select or attenuation value. For that reason the bench commits after partial shifts, after shifts attempted with enable high, and straight after power-down, so that each hidden state is brought out. A wrong active word or decode state shows up directly as a non-one-hot select or a mismatched field, and an output change without an `upd` pulse shows that the commit path has lost alignment.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
    localparam int WORD_W   = 8;
    localparam int VOL_W    = 3;
    localparam int STEP_DB  = 4;
    localparam int PATH_N   = 4;
    localparam int ATT_W    = $clog2((2**VOL_W - 1) * STEP_DB + 1);

    // field positions inside the control word
    localparam int TXA_BIT  = 7;
    localparam int TXB_BIT  = 6;
    localparam int DRV_BIT  = 5;
    localparam int AUX_BIT  = 4;
    localparam int VOL_LSB  = 0;

    localparam logic [WORD_W-1:0] WORD_INIT = 8'hA0;

    // serial pin lanes inside the synchroniser
    localparam int LANE_DAT = 0;
    localparam int LANE_CLK = 1;
    localparam int LANE_EN  = 2;
    localparam int LANES    = 3;

    typedef enum logic [1:0] {
        TX_MUTE  = 2'd0,
        TX_MIC_A = 2'd1,
        TX_MIC_B = 2'd2,
        TX_SUM   = 2'd3
    } tx_path_e;

    typedef enum logic [1:0] {
        RX_QUIET = 2'd0,
        RX_DRV   = 2'd1,
        RX_AUX   = 2'd2,
        RX_BOTH  = 2'd3
    } rx_path_e;
endpackage

// File: rtl/codec_ctl_sync.sv
module codec_ctl_sync #(
    parameter int              STAGES  = 2,
    parameter int              PINS    = 3,
    parameter logic [PINS-1:0] PIN_RST = '1
) (
    input  logic            clk,
    input  logic            pdn_n,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] lvl_o,
    output logic [PINS-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][PINS-1:0] pipe;
        logic [PINS-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            s_q.pipe <= {STAGES{PIN_RST}};
            s_q.prev <= PIN_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o = s_q.pipe[STAGES-1];

    for (genvar p = 0; p < PINS; p++) begin : g_edge
        assign rise_o[p] = s_q.pipe[STAGES-1][p] & ~s_q.prev[p];
    end
endmodule

// File: rtl/codec_ctl_shift.sv
module codec_ctl_shift #(
    parameter int                WIDTH = 8,
    parameter logic [WIDTH-1:0]  INIT  = 8'hA0
) (
    input  logic             clk,
    input  logic             pdn_n,
    input  logic             dclk_rise,
    input  logic             en_rise,
    input  logic             en_lvl,
    input  logic             dat_lvl,
    output logic [WIDTH-1:0] word_o,
    output logic             commit_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [WIDTH-1:0] word;
        logic             commit;
    } shf_st_t;

    shf_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.commit = 1'b0;
        if (dclk_rise && !en_lvl) begin
            s_d.sh = {s_q.sh[WIDTH-2:0], dat_lvl};
        end
        if (en_rise) begin
            s_d.word   = s_q.sh;
            s_d.commit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            s_q.sh     <= '0;
            s_q.word   <= INIT;
            s_q.commit <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o   = s_q.word;
    assign commit_o = s_q.commit;

    // R7
    hold_word_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        !en_rise |=> $stable(s_q.word));

    // R9
    no_shift_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (!dclk_rise || en_lvl) |=> $stable(s_q.sh));
endmodule

// File: rtl/codec_ctl_decode.sv
module codec_ctl_decode
    import codec_ctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] INIT = WORD_INIT
) (
    input  logic                 clk,
    input  logic                 pdn_n,
    input  logic [WORD_W-1:0]    word_i,
    input  logic                 commit_i,
    output logic [PATH_N-1:0]    tx_sel_o,
    output logic [PATH_N-1:0]    rx_sel_o,
    output logic                 drv_en_o,
    output logic                 aux_en_o,
    output logic [VOL_W-1:0]     vol_o,
    output logic [ATT_W-1:0]     att_o,
    output logic                 upd_o
);
    typedef struct packed {
        logic [PATH_N-1:0] tx;
        logic [PATH_N-1:0] rx;
        logic              drv;
        logic              aux;
        logic [VOL_W-1:0]  vol;
        logic [ATT_W-1:0]  att;
        logic              upd;
    } dec_st_t;

    function automatic dec_st_t decode_word(input logic [WORD_W-1:0] w);
        dec_st_t  r;
        tx_path_e tp;
        rx_path_e rp;
        tp    = tx_path_e'({w[TXB_BIT], w[TXA_BIT]});
        rp    = rx_path_e'({w[AUX_BIT], w[DRV_BIT]});
        r.tx  = '0;
        r.rx  = '0;
        for (int i = 0; i < PATH_N; i++) begin
            r.tx[i] = (int'(tp) == i);
            r.rx[i] = (int'(rp) == i);
        end
        r.drv = w[DRV_BIT];
        r.aux = w[AUX_BIT];
        r.vol = w[VOL_LSB +: VOL_W];
        r.att = ATT_W'(STEP_DB) * ATT_W'(w[VOL_LSB +: VOL_W]);
        r.upd = 1'b0;
        return r;
    endfunction

    dec_st_t s_d, s_q;

    always_comb begin
        s_d     = decode_word(word_i);
        s_d.upd = commit_i;
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            s_q <= decode_word(INIT);
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_sel_o = s_q.tx;
    assign rx_sel_o = s_q.rx;
    assign drv_en_o = s_q.drv;
    assign aux_en_o = s_q.aux;
    assign vol_o    = s_q.vol;
    assign att_o    = s_q.att;
    assign upd_o    = s_q.upd;

    // R3
    tx_onehot_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        $countones(s_q.tx) == 1);

    // R4
    rx_onehot_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        $countones(s_q.rx) == 1);

    // R4
    rx_enable_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (s_q.drv == (s_q.rx[1] | s_q.rx[3])) && (s_q.aux == (s_q.rx[2] | s_q.rx[3])));

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        !commit_i |=> $stable({s_q.tx, s_q.rx, s_q.vol}));
endmodule

// File: rtl/codec_ctl_reg.sv
module codec_ctl_reg
    import codec_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        pdn_n,
    input  logic        ctl_en,
    input  logic        ctl_clk,
    input  logic        ctl_dat,
    output logic [3:0]  tx_sel,
    output logic [3:0]  rx_sel,
    output logic        rx_drv_en,
    output logic        rx_aux_en,
    output logic [2:0]  vol_idx,
    output logic [4:0]  atten_db,
    output logic        upd
);
    logic [LANES-1:0]  pin_lvl, pin_rise;
    logic [WORD_W-1:0] word;
    logic              commit;

    codec_ctl_sync #(
        .STAGES (SYNC_STAGES),
        .PINS   (LANES),
        .PIN_RST('1)
    ) u_sync (
        .clk   (clk),
        .pdn_n (pdn_n),
        .pin_i ({ctl_en, ctl_clk, ctl_dat}),
        .lvl_o (pin_lvl),
        .rise_o(pin_rise)
    );

    codec_ctl_shift #(
        .WIDTH(WORD_W),
        .INIT (WORD_INIT)
    ) u_shift (
        .clk      (clk),
        .pdn_n    (pdn_n),
        .dclk_rise(pin_rise[LANE_CLK]),
        .en_rise  (pin_rise[LANE_EN]),
        .en_lvl   (pin_lvl[LANE_EN]),
        .dat_lvl  (pin_lvl[LANE_DAT]),
        .word_o   (word),
        .commit_o (commit)
    );

    codec_ctl_decode #(
        .INIT(WORD_INIT)
    ) u_dec (
        .clk     (clk),
        .pdn_n   (pdn_n),
        .word_i  (word),
        .commit_i(commit),
        .tx_sel_o(tx_sel),
        .rx_sel_o(rx_sel),
        .drv_en_o(rx_drv_en),
        .aux_en_o(rx_aux_en),
        .vol_o   (vol_idx),
        .att_o   (atten_db),
        .upd_o   (upd)
    );

    // R8
    upd_width_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        upd |=> !upd);
endmodule

// File: tb/sim_codec_ctl_reg.sv
module sim_codec_ctl_reg;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 3;

    logic clk = 1'b0;
    logic pdn_n = 1'b0;
    logic ctl_en = 1'b1;
    logic ctl_clk = 1'b0;
    logic ctl_dat = 1'b0;
    logic [3:0] tx_sel, rx_sel;
    logic rx_drv_en, rx_aux_en, upd;
    logic [2:0] vol_idx;
    logic [4:0] atten_db;

    int checks = 0, fails = 0;
    int upd_cnt = 0, exp_upd = 0, wide_cnt = 0;
    logic prev_upd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_ctl_reg u0 (
        .clk(clk), .pdn_n(pdn_n), .ctl_en(ctl_en), .ctl_clk(ctl_clk),
        .ctl_dat(ctl_dat), .tx_sel(tx_sel), .rx_sel(rx_sel),
        .rx_drv_en(rx_drv_en), .rx_aux_en(rx_aux_en), .vol_idx(vol_idx),
        .atten_db(atten_db), .upd(upd)
    );

    always @(posedge clk) begin
        if (pdn_n && upd) upd_cnt++;
        if (upd && prev_upd) wide_cnt++;
        prev_upd = upd;
    end

    // {word, tx_sel, rx_sel, vol_idx, atten_db}
    localparam logic [23:0] VEC [10] = '{
        {8'h00, 4'b0001, 4'b0001, 3'd0, 5'd0},
        {8'h80, 4'b0010, 4'b0001, 3'd0, 5'd0},
        {8'h40, 4'b0100, 4'b0001, 3'd0, 5'd0},
        {8'hC0, 4'b1000, 4'b0001, 3'd0, 5'd0},
        {8'h20, 4'b0001, 4'b0010, 3'd0, 5'd0},
        {8'h10, 4'b0001, 4'b0100, 3'd0, 5'd0},
        {8'h37, 4'b0001, 4'b1000, 3'd7, 5'd28},
        {8'h0D, 4'b0001, 4'b0001, 3'd5, 5'd20},
        {8'hE3, 4'b1000, 4'b0010, 3'd3, 5'd12},
        {8'h92, 4'b0010, 4'b0100, 3'd2, 5'd8}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ctl_dat = b;
        wait_clk(PH);
        ctl_clk = 1'b1;
        wait_clk(PH);
        ctl_clk = 1'b0;
    endtask

    task automatic commit_now();
        ctl_en = 1'b1;
        exp_upd++;
        wait_clk(8);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        ctl_en = 1'b0;
        wait_clk(PH);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
        wait_clk(PH);
        commit_now();
    endtask

    task automatic check_out(input string tag, input logic [3:0] tx, input logic [3:0] rx,
                             input logic [2:0] vol, input logic [4:0] att);
        chk({tag, " tx_sel"}, tx_sel, tx);
        chk({tag, " rx_sel"}, rx_sel, rx);
        chk({tag, " rx_drv_en"}, rx_drv_en, rx[1] | rx[3]);
        chk({tag, " rx_aux_en"}, rx_aux_en, rx[2] | rx[3]);
        chk({tag, " vol_idx"}, vol_idx, vol);
        chk({tag, " atten_db"}, atten_db, att);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        // R6 defaults during power-down
        check_out("R6 reset", 4'b0010, 4'b0010, 3'd0, 5'd0);
        chk("R6 upd", upd, 0);
        pdn_n = 1'b1;
        wait_clk(6);
        // R7 defaults kept after release, data clock without enable edge
        ctl_en = 1'b0;
        wait_clk(PH);
        for (int i = 0; i < 8; i++) shift_bit(1'b1);
        wait_clk(6);
        check_out("R7 hold", 4'b0010, 4'b0010, 3'd0, 5'd0);
        chk("R7 no upd", upd_cnt, 0);

        // R1 R3 R4 R5 table of full words
        for (int k = 0; k < 10; k++) begin
            send_bits(VEC[k][23:16], 8);
            check_out($sformatf("R1/R3/R4/R5 vec%0d", k), VEC[k][15:12], VEC[k][11:8],
                      VEC[k][7:5], VEC[k][4:0]);
        end
        // R8 one pulse per commit, one cycle wide
        chk("R8 upd count", upd_cnt, exp_upd);
        chk("R8 upd width", wide_cnt, 0);

        // R9 data clock edges with enable high are ignored
        send_bits(8'h37, 8);
        ctl_en = 1'b1;
        wait_clk(PH);
        for (int i = 0; i < 8; i++) shift_bit(1'b1);
        ctl_en = 1'b0;
        wait_clk(4);
        commit_now();
        check_out("R9 ignored shifts", 4'b0001, 4'b1000, 3'd7, 5'd28);

        // R2 partial shift: 0xC0 then three bits 101 -> 0x05
        send_bits(8'hC0, 8);
        send_bits(8'h05, 3);
        check_out("R2 partial", 4'b0001, 4'b0001, 3'd5, 5'd20);

        // R6 power-down mid-operation restores defaults and clears shift register
        send_bits(8'hE3, 8);
        pdn_n = 1'b0;
        wait_clk(3);
        check_out("R6 pdn", 4'b0010, 4'b0010, 3'd0, 5'd0);
        chk("R6 pdn upd", upd, 0);
        pdn_n = 1'b1;
        wait_clk(4);
        // R7 still defaults after release
        check_out("R7 after pdn", 4'b0010, 4'b0010, 3'd0, 5'd0);
        ctl_en = 1'b0;
        wait_clk(4);
        commit_now();
        check_out("R6 cleared shift", 4'b0001, 4'b0001, 3'd0, 5'd0);

        chk("R8 final upd count", upd_cnt, exp_upd);
        chk("R8 final upd width", wide_cnt, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule